// File: doc/BRIEF.md
# Learned Capacity Tracking Counter

This block keeps a running count of the charge left in a rechargeable battery and learns how much charge the battery holds when full. An available-charge counter steps up on each charge count pulse and steps down on each discharge pulse and each self-discharge pulse. It never drops below zero and never rises above a full-capacity reference.

The full-capacity reference starts from a programmed constant. It is re-learned from the charge that was actually drawn out. After the end-of-discharge indicator has been seen, the next valid charge event replaces the reference with the measured discharge count, provided the measurement is marked as qualified. Any single update may shrink the reference by at most about six percent. The shrink factor is 241/256, truncated.

The block also holds a valid-charge flag. A byte-wide register port lets a host read both values and overwrite the available count.

Top module: `capacity_learner`

## Requirements
- R1: After reset the available count is 0, the full reference equals parameter FULL_INIT, and the valid-charge flag is 0.
- R2: A charge pulse with no discharge-type pulse raises the available count by 1. The count holds when it already equals the full reference.
- R3: Each discharge pulse and each self-discharge pulse lowers the count by 1. When both arrive in the same cycle the count drops by 2. The count floors at 0.
- R4: A charge pulse in the same cycle as exactly one discharge-type pulse leaves the count unchanged.
- R5: A learning update needs three things: the end-of-discharge input has been high, a valid charge event follows, and the discharge qualifier is high during that event. The full reference then becomes the discharge count. Only the first such event after the end-of-discharge indication updates the reference.
- R6: During a learning update, if the discharge count is below (full*241)>>8, the full reference becomes (full*241)>>8 instead.
- R7: A valid charge event with the qualifier low leaves the full reference unchanged. It still uses up the pending learning opportunity.
- R8: A valid charge event sets the valid-charge flag. A discharge pulse while the count equals the full reference clears the flag. A self-discharge pulse does not clear it.
- R9: Reads are combinational. Address 03h returns the count's upper byte and 17h its lower byte. Address 05h returns the full reference's upper byte and 06h its lower byte. Any other address reads 0.
- R10: A write to 03h or 17h replaces that byte of the count, clamped to the full reference. The write takes priority over count pulses in the same cycle.
- R11: Writes to 05h, 06h or any unmapped address change nothing.
- R12: When a learning update lowers the full reference below the available count, the count is clamped to the new reference in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chgPulse | input | 1 | One-cycle charge count |
| dsgPulse | input | 1 | One-cycle discharge count |
| selfDsgPulse | input | 1 | One-cycle self-discharge count |
| validChgEvt | input | 1 | One-cycle valid charge event |
| emptyFlag | input | 1 | End-of-discharge indicator |
| dischargeValid | input | 1 | Qualifier for the measured discharge |
| dischargeCount | input | CNT_W | Measured discharge count |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| availCount | output | CNT_W | Available charge count |
| fullRef | output | CNT_W | Learned full-capacity reference |
| validChgFlag | output | 1 | Valid-charge flag |

## Verification
Pulses, writes and learning events take effect at the clock edge that samples them. The count, the reference and the flag therefore show the new value one cycle later, and that is where the bench looks. Register reads are combinational and are sampled a short delay after the address is set, with no clock edge in between. Stimulus changes on the falling edge and results are taken on the next falling edge, one rising edge later, so no check depends on the order of events at the rising edge.

// File: rtl/capl_pkg.sv
package capl_pkg;
  localparam logic [7:0] ADDR_AVAIL_HI = 8'h03;
  localparam logic [7:0] ADDR_AVAIL_LO = 8'h17;
  localparam logic [7:0] ADDR_FULL_HI  = 8'h05;
  localparam logic [7:0] ADDR_FULL_LO  = 8'h06;
  localparam int SHRINK_NUM   = 241;
  localparam int SHRINK_SHIFT = 8;

  typedef struct packed {
    logic incr;
    logic decrOne;
    logic decrTwo;
    logic wrAvailHi;
    logic wrAvailLo;
    logic learn;
  } ctrlStrobes_t;
endpackage

// File: rtl/capl_control.sv
module capl_control
  import capl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chgPulse,
  input  logic         dsgPulse,
  input  logic         selfDsgPulse,
  input  logic         validChgEvt,
  input  logic         emptyFlag,
  input  logic         dischargeValid,
  input  logic [7:0]   regAddr,
  input  logic         regWrEn,
  input  logic         atFull,
  output ctrlStrobes_t stb,
  output logic         vqFlag
);
  logic armedQ;
  logic wrHi, wrLo, wrAvail;
  logic [1:0] downCnt;

  assign wrHi    = regWrEn && (regAddr == ADDR_AVAIL_HI);
  assign wrLo    = regWrEn && (regAddr == ADDR_AVAIL_LO);
  assign wrAvail = wrHi || wrLo;
  assign downCnt = {1'b0, dsgPulse} + {1'b0, selfDsgPulse};

  always_comb begin
    stb = '0;
    stb.wrAvailHi = wrHi;
    stb.wrAvailLo = wrLo;
    stb.learn     = validChgEvt && armedQ && dischargeValid;
    if (!wrAvail) begin
      if (chgPulse) begin
        stb.incr    = (downCnt == 2'd0);
        stb.decrOne = (downCnt == 2'd2);
      end else begin
        stb.decrOne = (downCnt == 2'd1);
        stb.decrTwo = (downCnt == 2'd2);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      vqFlag <= 1'b0;
    end else begin
      if (emptyFlag)        armedQ <= 1'b1;
      else if (validChgEvt) armedQ <= 1'b0;
      if (validChgEvt)                vqFlag <= 1'b1;
      else if (dsgPulse && atFull)    vqFlag <= 1'b0;
    end
  end

  p_vq_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    validChgEvt |=> vqFlag);

  p_cancel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chgPulse && (dsgPulse ^ selfDsgPulse) && !wrAvail)
      |-> !(stb.incr || stb.decrOne || stb.decrTwo));

  p_no_learn_unqualified_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dischargeValid |-> !stb.learn);
endmodule

// File: rtl/capl_datapath.sv
module capl_datapath
  import capl_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] FULL_INIT = CNT_W'(4000)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     stb,
  input  logic [CNT_W-1:0] dischargeCount,
  input  logic [7:0]       wrData,
  input  logic [7:0]       rdAddr,
  output logic [CNT_W-1:0] availQ,
  output logic [CNT_W-1:0] fullQ,
  output logic             atFull,
  output logic [7:0]       rdData
);
  localparam int PROD_W = CNT_W + SHRINK_SHIFT;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  shrunk;
  logic [CNT_W-1:0]  stepNext, fullNext, availNext;
  logic [15:0]       availWide, fullWide, wrCand;

  assign prod      = PROD_W'(fullQ) * PROD_W'(SHRINK_NUM);
  assign shrunk    = prod[PROD_W-1:SHRINK_SHIFT];
  assign availWide = 16'(availQ);
  assign fullWide  = 16'(fullQ);
  assign atFull    = (availQ == fullQ);

  always_comb begin
    wrCand = availWide;
    if (stb.wrAvailHi) wrCand = {wrData, availWide[7:0]};
    if (stb.wrAvailLo) wrCand = {availWide[15:8], wrData};
  end

  always_comb begin
    stepNext = availQ;
    if (stb.wrAvailHi || stb.wrAvailLo)
      stepNext = (wrCand > fullWide) ? fullQ : CNT_W'(wrCand);
    else if (stb.incr)
      stepNext = (availQ >= fullQ) ? fullQ : availQ + 1'b1;
    else if (stb.decrTwo)
      stepNext = (availQ < CNT_W'(2)) ? '0 : availQ - CNT_W'(2);
    else if (stb.decrOne)
      stepNext = (availQ == '0) ? '0 : availQ - 1'b1;

    fullNext = fullQ;
    if (stb.learn)
      fullNext = (dischargeCount < shrunk) ? shrunk : dischargeCount;

    availNext = (stepNext > fullNext) ? fullNext : stepNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      availQ <= '0;
      fullQ  <= FULL_INIT;
    end else begin
      availQ <= availNext;
      fullQ  <= fullNext;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_AVAIL_HI: rdData = availWide[15:8];
      ADDR_AVAIL_LO: rdData = availWide[7:0];
      ADDR_FULL_HI:  rdData = fullWide[15:8];
      ADDR_FULL_LO:  rdData = fullWide[7:0];
      default:       rdData = 8'h00;
    endcase
  end

  p_avail_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    availQ <= fullQ);

  p_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decrOne && availQ == '0 && !stb.learn) |=> availQ == '0);

  p_shrink_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.learn && dischargeCount < shrunk) |=> fullQ == $past(shrunk));

  p_learn_clamp_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.learn |=> availQ <= fullQ);
endmodule

// File: rtl/capacity_learner.sv
module capacity_learner
  import capl_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] FULL_INIT = CNT_W'(4000)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chgPulse,
  input  logic             dsgPulse,
  input  logic             selfDsgPulse,
  input  logic             validChgEvt,
  input  logic             emptyFlag,
  input  logic             dischargeValid,
  input  logic [CNT_W-1:0] dischargeCount,
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  output logic [CNT_W-1:0] availCount,
  output logic [CNT_W-1:0] fullRef,
  output logic             validChgFlag
);
  ctrlStrobes_t stb;
  logic atFull;

  capl_control ctrl_i (
    .clk(clk), .rstN(rstN), .chgPulse(chgPulse), .dsgPulse(dsgPulse),
    .selfDsgPulse(selfDsgPulse), .validChgEvt(validChgEvt),
    .emptyFlag(emptyFlag), .dischargeValid(dischargeValid),
    .regAddr(regAddr), .regWrEn(regWrEn), .atFull(atFull),
    .stb(stb), .vqFlag(validChgFlag)
  );

  capl_datapath #(.CNT_W(CNT_W), .FULL_INIT(FULL_INIT)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dischargeCount(dischargeCount),
    .wrData(regWrData), .rdAddr(regAddr), .availQ(availCount),
    .fullQ(fullRef), .atFull(atFull), .rdData(regRdData)
  );

  initial begin
    a_width_r9: assert (CNT_W >= 9 && CNT_W <= 16)
      else $error("CNT_W out of range");
  end
endmodule

// File: tb/capacity_learner_tb.sv
module capacity_learner_tb_top;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] FULL0 = 16'd20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chgPulse = 0, dsgPulse = 0, selfDsgPulse = 0, validChgEvt = 0;
  logic emptyFlag = 0, dischargeValid = 0;
  logic [CNT_W-1:0] dischargeCount = '0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic regWrEn = 0;
  logic [7:0] regRdData;
  logic [CNT_W-1:0] availCount, fullRef;
  logic validChgFlag;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  capacity_learner #(.CNT_W(CNT_W), .FULL_INIT(FULL0)) dut_i (
    .clk(clk), .rstN(rstN), .chgPulse(chgPulse), .dsgPulse(dsgPulse),
    .selfDsgPulse(selfDsgPulse), .validChgEvt(validChgEvt),
    .emptyFlag(emptyFlag), .dischargeValid(dischargeValid),
    .dischargeCount(dischargeCount), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .availCount(availCount),
    .fullRef(fullRef), .validChgFlag(validChgFlag)
  );

  // {chg, dsg, self, expected count}, starting from count 0, full 20
  localparam logic [10:0] VEC [12] = '{
    {3'b010, 8'd0}, {3'b100, 8'd1}, {3'b100, 8'd2}, {3'b100, 8'd3},
    {3'b110, 8'd3}, {3'b001, 8'd2}, {3'b011, 8'd0}, {3'b111, 8'd0},
    {3'b100, 8'd1}, {3'b101, 8'd1}, {3'b100, 8'd2}, {3'b011, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chgPulse = 0; dsgPulse = 0; selfDsgPulse = 0; validChgEvt = 0;
    emptyFlag = 0; regWrEn = 0;
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    step();
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input int exp);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic learnCycle(input logic q, input int cnt);
    emptyFlag = 1;
    step();
    dischargeValid = q; dischargeCount = CNT_W'(cnt); validChgEvt = 1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 count", availCount, 0);
    chk("R1 full", fullRef, 20);
    chk("R1 flag", validChgFlag, 0);

    for (int i = 0; i < 12; i++) begin
      chgPulse = VEC[i][10]; dsgPulse = VEC[i][9]; selfDsgPulse = VEC[i][8];
      step();
      chk("R2/R3/R4 vector", availCount, VEC[i][7:0]);
    end

    hostWrite(8'h17, 8'd19);
    chk("R10 low write", availCount, 19);
    hostWrite(8'h03, 8'd1);
    chk("R10 clamp", availCount, 20);
    chgPulse = 1; step();
    chk("R2 saturate", availCount, 20);
    readChk("R9 full hi", 8'h05, 0);
    readChk("R9 full lo", 8'h06, 20);
    readChk("R9 avail hi", 8'h03, 0);
    readChk("R9 avail lo", 8'h17, 20);
    readChk("R9 unmapped", 8'h42, 0);
    hostWrite(8'h05, 8'hFF);
    hostWrite(8'h06, 8'h01);
    hostWrite(8'h42, 8'h07);
    chk("R11 full", fullRef, 20);
    chk("R11 count", availCount, 20);

    validChgEvt = 1; dischargeValid = 1; dischargeCount = 16'd50; step();
    chk("R8 set", validChgFlag, 1);
    chk("R5 not armed", fullRef, 20);
    dsgPulse = 1; step();
    chk("R8 clear", validChgFlag, 0);
    chk("R3 dsg", availCount, 19);
    validChgEvt = 1; step();
    chgPulse = 1; step();
    selfDsgPulse = 1; step();
    chk("R8 self keeps", validChgFlag, 1);
    chk("R3 self", availCount, 19);

    learnCycle(1, 30);
    chk("R5 load", fullRef, 30);
    dischargeCount = 16'd40; validChgEvt = 1; step();
    chk("R5 once", fullRef, 30);
    learnCycle(1, 5);
    chk("R6 shrink", fullRef, 28);
    hostWrite(8'h17, 8'd28);
    chk("R10 write", availCount, 28);
    learnCycle(1, 10);
    chk("R6 shrink2", fullRef, 26);
    chk("R12 clamp", availCount, 26);
    learnCycle(0, 100);
    chk("R7 unqualified", fullRef, 26);
    dischargeValid = 1; validChgEvt = 1; step();
    chk("R7 consumed", fullRef, 26);

    regAddr = 8'h17; regWrData = 8'd5; regWrEn = 1; chgPulse = 1; step();
    chk("R10 priority chg", availCount, 5);
    regAddr = 8'h17; regWrData = 8'd9; regWrEn = 1; dsgPulse = 1; step();
    chk("R10 priority dsg", availCount, 9);

    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 count again", availCount, 0);
    chk("R1 full again", fullRef, 20);
    chk("R1 flag again", validChgFlag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule